// File: doc/BRIEF.md
# Framed Serial Register Loader

This block accepts 16-bit command words on a three-wire serial port (active-low frame line, serial clock, data line). It decodes each completed word into writes to a control register, two 28-bit frequency-tuning registers and two 12-bit phase-offset registers. It then presents all of them to a synthesis core that runs on the master clock.

The two top bits of each word choose the target. Two control bits set how frequency words are applied. With the full-width bit set, a frequency register is loaded by two words in a row to the same target: the first carries the low 14 bits and is held in a staging register, and the second carries the high 14 bits and commits all 28 bits at once. With the full-width bit clear, each frequency word replaces only one 14-bit half, and the half-select bit picks which one.

Serial capture runs on the falling edge of the serial clock. Completed words cross into the master clock domain through a toggle handshake, and all register updates take place there.

Top module: `sreg_loader`

## Requirements
- R1: A word is 16 bits sent MSB first while `fsync_ni` is low, and each bit is sampled on a falling edge of `sclk_i`.
- R2: A frame in which `fsync_ni` returns high before 16 falling edges have occurred is discarded and changes no register.
- R3: Word bits [15:14] pick the target: 00 control, 01 frequency 0, 10 frequency 1, 11 phase.
- R4: A control write stores the word in `ctrl_o`, and bits 0, 2 and 4 always read 0. Bit 13 is the full-width bit and bit 12 is the half-select bit.
- R5: With control bit 13 set, the first frequency word is staged and leaves the outputs unchanged. A second word to the same frequency target then loads {second[13:0], first[13:0]} in a single update.
- R6: A staged low half is dropped by any intervening non-frequency word. A word to the other frequency target is treated as a new first word for that target.
- R7: With control bit 13 clear, a frequency word writes data bits [13:0] into bits [27:14] when control bit 12 is 1, or into bits [13:0] when it is 0. The other half keeps its value.
- R8: A phase word writes bits [11:0] to phase register 1 when bit 13 is 1, or to phase register 0 when bit 13 is 0. Bit 12 has no effect.
- R9: After reset, every register output is zero.
- R10: Outputs change only because of a completed word, at most one register changes per word, and the change appears on the third rising master-clock edge after the 16th falling serial edge.
- R11: Falling serial edges after the 16th within the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, data sampled on falling edge |
| fsync_ni | input | 1 | Active-low frame signal |
| sdata_i | input | 1 | Serial data, MSB first |
| ctrl_o | output | 16 | Control register |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |

## Verification
A completed word toggles a flag in the serial domain. The flag passes through two synchroniser flops and one edge-detect flop, so the register update is due on the third rising master edge after the final falling serial edge. The latency check samples one master cycle after that serial edge and expects no change, then samples again well past the third edge and expects the new value. Every other scenario waits eight master cycles after the frame closes before it samples, which keeps each check clear of the crossing window. Checks that a word should have no effect (a staged first half, a short frame, extra serial edges, the unselected half) read the register that could have changed, after that word and before the next.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
  localparam int WORD_W  = 16;
  localparam int HALF_W  = 14;
  localparam int FREQ_W  = 2 * HALF_W;
  localparam int PHASE_W = 12;
  localparam int CTRL_FULL_BIT = 13;
  localparam int CTRL_HALF_BIT = 12;
  localparam int PH_SEL_BIT    = 13;
  localparam logic [WORD_W-1:0] CTRL_RSVD_MASK = 16'h0015;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'b00,
    TGT_FREQ0 = 2'b01,
    TGT_FREQ1 = 2'b10,
    TGT_PHASE = 2'b11
  } tgt_e;
endpackage

// File: rtl/sreg_shift.sv
`timescale 1ns/1ps
module sreg_shift #(
  parameter int W = 16
) (
  input  logic         sclk_i,
  input  logic         rst_ni,
  input  logic         fsync_ni,
  input  logic         sdata_i,
  output logic [W-1:0] word_o,
  output logic         tgl_o
);
  localparam int CW = $clog2(W + 1);

  logic          frame_rst_n;
  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;
  logic          full;

  // bit counter is held clear whenever the frame is inactive
  assign frame_rst_n = rst_ni & ~fsync_ni;
  assign full        = (cnt_q == CW'(W));

  always_ff @(negedge sclk_i or negedge frame_rst_n) begin
    if (!frame_rst_n) cnt_q <= '0;
    else if (!full)   cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_o <= '0;
      tgl_o  <= 1'b0;
    end else if (!fsync_ni && !full) begin
      sh_q <= {sh_q[W-3:0], sdata_i};
      if (cnt_q == CW'(W - 1)) begin
        word_o <= {sh_q, sdata_i};
        tgl_o  <= ~tgl_o;
      end
    end
  end
endmodule

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = q[STAGES] ^ q[STAGES-1];
endmodule

// File: rtl/sreg_regs.sv
`timescale 1ns/1ps
module sreg_regs
  import sreg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [WORD_W-1:0]  ctrl_o,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o,
  output logic               pend_o
);
  tgt_e              tgt;
  logic              fsel, is_freq, pend_sel_q, commit, stage_en;
  logic [HALF_W-1:0] stage_q, data;
  logic [FREQ_W-1:0] cur, nxt;

  assign tgt     = tgt_e'(word_i[WORD_W-1 -: 2]);
  assign fsel    = (tgt == TGT_FREQ1);
  assign is_freq = (tgt == TGT_FREQ0) || (tgt == TGT_FREQ1);
  assign data    = word_i[HALF_W-1:0];
  assign cur     = fsel ? freq1_o : freq0_o;

  always_comb begin
    commit   = 1'b0;
    stage_en = 1'b0;
    nxt      = cur;
    if (ctrl_o[CTRL_FULL_BIT]) begin
      if (pend_o && pend_sel_q == fsel) begin
        commit = 1'b1;
        nxt    = {data, stage_q};
      end else begin
        stage_en = 1'b1;
      end
    end else begin
      commit = 1'b1;
      if (ctrl_o[CTRL_HALF_BIT]) nxt[FREQ_W-1:HALF_W] = data;
      else                       nxt[HALF_W-1:0]      = data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      freq0_o    <= '0;
      freq1_o    <= '0;
      phase0_o   <= '0;
      phase1_o   <= '0;
      stage_q    <= '0;
      pend_o     <= 1'b0;
      pend_sel_q <= 1'b0;
    end else if (vld_i) begin
      pend_o <= 1'b0;
      if (is_freq) begin
        if (stage_en) begin
          stage_q    <= data;
          pend_o     <= 1'b1;
          pend_sel_q <= fsel;
        end
        if (commit) begin
          if (fsel) freq1_o <= nxt;
          else      freq0_o <= nxt;
        end
      end else if (tgt == TGT_CTRL) begin
        ctrl_o <= word_i & ~CTRL_RSVD_MASK;
      end else if (word_i[PH_SEL_BIT]) begin
        phase1_o <= word_i[PHASE_W-1:0];
      end else begin
        phase0_o <= word_i[PHASE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sreg_loader.sv
`timescale 1ns/1ps
module sreg_loader
  import sreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               fsync_ni,
  input  logic               sdata_i,
  output logic [WORD_W-1:0]  ctrl_o,
  output logic [FREQ_W-1:0]  freq0_o,
  output logic [FREQ_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase0_o,
  output logic [PHASE_W-1:0] phase1_o
);
  logic [WORD_W-1:0] word_q;
  logic              word_tgl, word_vld, pend;

  sreg_shift #(.W(WORD_W)) u_shift (
    .sclk_i  (sclk_i),
    .rst_ni  (rst_ni),
    .fsync_ni(fsync_ni),
    .sdata_i (sdata_i),
    .word_o  (word_q),
    .tgl_o   (word_tgl)
  );

  sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (word_tgl),
    .pulse_o(word_vld)
  );

  sreg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (word_vld),
    .word_i  (word_q),
    .ctrl_o  (ctrl_o),
    .freq0_o (freq0_o),
    .freq1_o (freq1_o),
    .phase0_o(phase0_o),
    .phase1_o(phase1_o),
    .pend_o  (pend)
  );
endmodule

// File: rtl/sreg_loader_chk.sv
`timescale 1ns/1ps
module sreg_loader_chk
  import sreg_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               word_vld,
  input logic [WORD_W-1:0]  word_q,
  input logic               pend,
  input logic [WORD_W-1:0]  ctrl_o,
  input logic [FREQ_W-1:0]  freq0_o,
  input logic [FREQ_W-1:0]  freq1_o,
  input logic [PHASE_W-1:0] phase0_o,
  input logic [PHASE_W-1:0] phase1_o
);
  logic is_freq_word;
  assign is_freq_word = (word_q[15:14] == 2'b01) || (word_q[15:14] == 2'b10);

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld |=> ($stable(ctrl_o) && $stable(freq0_o) && $stable(freq1_o)
                   && $stable(phase0_o) && $stable(phase1_o))); // R10

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |=> ($countones({ctrl_o != $past(ctrl_o), freq0_o != $past(freq0_o),
                              freq1_o != $past(freq1_o), phase0_o != $past(phase0_o),
                              phase1_o != $past(phase1_o)}) <= 1)); // R10

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |=> !word_vld); // R10

  AST_STAGE_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && is_freq_word && ctrl_o[CTRL_FULL_BIT] && !pend)
      |=> ($stable(freq0_o) && $stable(freq1_o))); // R5

  AST_HALF_KEEP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && is_freq_word && !ctrl_o[CTRL_FULL_BIT] && ctrl_o[CTRL_HALF_BIT])
      |=> ($stable(freq0_o[HALF_W-1:0]) && $stable(freq1_o[HALF_W-1:0]))); // R7

  AST_HALF_KEEP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && is_freq_word && !ctrl_o[CTRL_FULL_BIT] && !ctrl_o[CTRL_HALF_BIT])
      |=> ($stable(freq0_o[FREQ_W-1:HALF_W]) && $stable(freq1_o[FREQ_W-1:HALF_W]))); // R7

  AST_PHASE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && word_q[15:14] == 2'b11) |=>
      (word_q[PH_SEL_BIT] ? $stable(phase0_o) : $stable(phase1_o))); // R8

  AST_CTRL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o & CTRL_RSVD_MASK) == '0); // R4
endmodule

bind sreg_loader sreg_loader_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .word_vld(word_vld),
  .word_q  (word_q),
  .pend    (pend),
  .ctrl_o  (ctrl_o),
  .freq0_o (freq0_o),
  .freq1_o (freq1_o),
  .phase0_o(phase0_o),
  .phase1_o(phase1_o)
);

// File: tb/sreg_loader_tb.sv
`timescale 1ns/1ps
module sreg_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        fsync_n = 1'b1;
  logic        sdata = 1'b0;
  logic [15:0] ctrl;
  logic [27:0] f0, f1;
  logic [11:0] p0, p1;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sreg_loader u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sclk_i  (sclk),
    .fsync_ni(fsync_n),
    .sdata_i (sdata),
    .ctrl_o  (ctrl),
    .freq0_o (f0),
    .freq1_o (f1),
    .phase0_o(p0),
    .phase1_o(p1)
  );

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // n bits of w MSB first, then extra bits of 1 in the same frame; no trailing wait
  task automatic send_raw(input logic [15:0] w, input int n, input int extra);
    fsync_n = 1'b0;
    #10;
    for (int i = 0; i < n + extra; i++) begin
      sdata = (i < n) ? w[15-i] : 1'b1;
      sclk  = 1'b1;
      #10;
      sclk  = 1'b0;
      #10;
    end
    #5 fsync_n = 1'b1;
    sclk = 1'b1;
  endtask

  task automatic send(input logic [15:0] w);
    send_raw(w, 16, 0);
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R9 ctrl", 28'(ctrl), 28'h0);
    chk("R9 freq0", f0, 28'h0);
    chk("R9 freq1", f1, 28'h0);
    chk("R9 phase", 28'({p1, p0}), 28'h0);
  endtask

  task automatic t_ctrl;
    send(16'h3FFF);
    chk("R4 R3 R1 ctrl reserved bits zero", 28'(ctrl), 28'h0003FEA);
  endtask

  task automatic t_full_load;
    send(16'h2000);
    send(16'h4000 | 16'h1234);
    chk("R5 staged word leaves freq0", f0, 28'h0);
    send(16'h4000 | 16'h0ABC);
    chk("R5 full load freq0", f0, {14'h0ABC, 14'h1234});
    chk("R5 freq1 untouched", f1, 28'h0);
  endtask

  task automatic t_restart;
    send(16'h4000 | 16'h0111);
    send(16'h8000 | 16'h0222);
    chk("R6 other target restarts", f0, {14'h0ABC, 14'h1234});
    send(16'h8000 | 16'h0333);
    chk("R6 freq1 from new pair", f1, {14'h0333, 14'h0222});
    send(16'h4000 | 16'h0044);
    send(16'h2000);
    send(16'h4000 | 16'h0055);
    chk("R6 control word drops staged half", f0, {14'h0ABC, 14'h1234});
    send(16'h4000 | 16'h0066);
    chk("R6 freq0 after interruption", f0, {14'h0066, 14'h0055});
  endtask

  task automatic t_half;
    send(16'h1000);
    send(16'h8000 | 16'h3FFF);
    chk("R7 upper half write", f1, {14'h3FFF, 14'h0222});
    send(16'h0000);
    send(16'h8000 | 16'h0001);
    chk("R7 lower half write", f1, {14'h3FFF, 14'h0001});
  endtask

  task automatic t_phase;
    send(16'hC000 | 16'h1ABC);
    chk("R8 phase0 with bit12 set", 28'(p0), 28'hABC);
    send(16'hE000 | 16'h0123);
    chk("R8 phase1", 28'(p1), 28'h123);
    chk("R8 phase0 kept", 28'(p0), 28'hABC);
  endtask

  task automatic t_short;
    send_raw(16'hC000 | 16'h0FFF, 10, 0);
    repeat (8) @(posedge clk);
    #1;
    chk("R2 short frame discarded", 28'(p0), 28'hABC);
    send(16'hC000 | 16'h0055);
    chk("R2 next full frame accepted", 28'(p0), 28'h055);
  endtask

  task automatic t_extra;
    send_raw(16'hE000 | 16'h0456, 16, 3);
    repeat (8) @(posedge clk);
    #1;
    chk("R11 extra edges ignored", 28'(p1), 28'h456);
  endtask

  task automatic t_latency;
    fsync_n = 1'b0;
    #10;
    for (int i = 0; i < 16; i++) begin
      sdata = (16'hC000 | 16'h0777) >> (15 - i);
      sclk  = 1'b1;
      #10;
      sclk  = 1'b0;
      if (i < 15) #10;
    end
    @(posedge clk);
    #1;
    chk("R10 no change one cycle after last edge", 28'(p0), 28'h055);
    #10 fsync_n = 1'b1;
    sclk = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk("R10 change after crossing", 28'(p0), 28'h777);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_ctrl;
    t_full_load;
    t_restart;
    t_half;
    t_phase;
    t_short;
    t_extra;
    t_latency;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule